// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver with Address Filtering

This block is a full-duplex asynchronous serial port. The transmitter and the receiver share one frame format that software sets through an 8-bit configuration register. The format has 5 to 8 data bits, an optional ninth slot that carries either a parity bit or a free extra data bit, and a stop period that is either short or long. Both directions are timed by a baud tick input that pulses for one clock sixteen times per bit period. Baud generation is outside the block.

Software loads a byte with `tx_wr` while `tx_busy` is low. A received character appears on `rx_data`, right-aligned, together with `rx_valid` and its error flags. A one-cycle `rx_rd` pulse consumes the character.

On a shared bus a node can enable address filtering. In that mode, frames whose extra bit is 0 are treated as data for other nodes and are dropped silently. Frames whose extra bit is 1 are delivered as address frames.

Top module: `sercom_uart`

## Requirements
- R1: Configuration bits [1:0] select the data length as 5 + value (00 gives 5 bits, 11 gives 8 bits). Data bits go out on `txd` least significant bit first, and only that many bits of `tx_data` are sent.
- R2: A frame is one start bit at 0, the data bits, an optional ninth slot, and a stop period at 1. Each bit lasts 16 baud ticks, and `txd` rests at 1 whenever `tx_busy` is low.
- R3: Configuration bit [2] enables parity. Bits [4:3] select its kind: 0 odd, 1 even, 2 always 1, 3 always 0. Odd and even are taken over the data bits that are actually sent.
- R4: Configuration bit [5] enables the extra bit, whose value is taken from `tx_xbit` when the byte is loaded. When parity is also enabled, parity occupies the ninth slot and the extra bit is neither sent nor reported.
- R5: Configuration bit [6] selects the long stop period. The stop period lasts 16 ticks when short, 32 ticks when long with 6 to 8 data bits, and 24 ticks when long with 5 data bits. `tx_busy` falls when the stop period ends.
- R6: A received character is presented on `rx_data` right-aligned, with its unused upper bits at 0. `rx_xbit` carries the received extra bit when the extra bit is enabled and parity is off, and is 0 otherwise. `rx_valid` is set when the stop bit is sampled.
- R7: The receiver confirms a start bit only if the line is still low half a bit after the falling edge. A low pulse shorter than that produces no character.
- R8: `rx_perr` is set with a character whose received parity bit differs from the parity computed over its data under the selected kind.
- R9: `rx_ferr` is set with a character whose first stop bit is sampled as 0.
- R10: If a character completes while `rx_valid` is still set and no `rx_rd` arrives in that cycle, the new character replaces the old one and `rx_ovr` is set. `rx_rd` clears both `rx_valid` and `rx_ovr`, and `rx_ovr` is never set without `rx_valid`.
- R11: With configuration bit [7] set together with bit [5] and with parity off, a frame whose extra bit is 0 changes no receive output. A frame whose extra bit is 1 is delivered with `rx_xbit` = 1. With bit [5] clear, bit [7] has no effect.
- R12: A `tx_wr` pulse while `tx_busy` is high is ignored. The frame in progress is unchanged, and no second frame follows.
- R13: Transmit and receive run concurrently and independently. With `txd` looped back to `rxd`, every sent character is received intact under every format. The configuration register reads back on `cfg_dout` and resets to 0x03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| cfg_wr | input | 1 | Write strobe for the format register |
| cfg_din | input | 8 | Format register write value |
| cfg_dout | output | 8 | Format register read value |
| tx_wr | input | 1 | Load a character for transmission |
| tx_data | input | 8 | Character to transmit |
| tx_xbit | input | 1 | Extra bit value sent with the character |
| tx_busy | output | 1 | A frame is being transmitted |
| rx_rd | input | 1 | Consume the received character |
| rx_data | output | 8 | Received character, right-aligned |
| rx_xbit | output | 1 | Received extra bit |
| rx_valid | output | 1 | A received character is waiting |
| rx_perr | output | 1 | Parity mismatch in the waiting character |
| rx_ferr | output | 1 | Stop bit sampled low in the waiting character |
| rx_ovr | output | 1 | A character was overwritten before it was read |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The bound assertions check the rules that hold at every cycle: the idle line at mark, the first transmitted bit at space, and the overrun flag following the receive flag and clearing on a read. Only the bench scenarios can show the bit-by-bit content of frames, parity values, stop-period lengths and address filtering. It sweeps every data length, every parity kind, the extra bit and both stop lengths in loopback. It drives hand-built frames onto `rxd` to inject parity and framing errors, short glitches and overruns.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } par_kind_e;

  // Packed from MSB: addr filter, long stop, extra bit, parity kind, parity on, length.
  typedef struct packed {
    logic      mp_en;
    logic      long_stop;
    logic      xb_en;
    par_kind_e par_kind;
    logic      par_en;
    logic [1:0] len_code;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    LN_IDLE  = 3'd0,
    LN_START = 3'd1,
    LN_DATA  = 3'd2,
    LN_OPT   = 3'd3,
    LN_STOP  = 3'd4
  } ln_state_e;

  localparam logic [7:0] CFG_RESET = 8'h03;

  function automatic logic [7:0] len_mask(input logic [1:0] len_code);
    return 8'hFF >> (2'd3 - len_code);
  endfunction

  function automatic logic [2:0] last_idx(input logic [1:0] len_code);
    return 3'd4 + {1'b0, len_code};
  endfunction

  function automatic logic par_value(input frame_cfg_t c, input logic [7:0] d);
    logic [7:0] md;
    md = d & len_mask(c.len_code);
    case (c.par_kind)
      PAR_ODD:  return ~(^md);
      PAR_EVEN: return ^md;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sercom_cfg.sv
module sercom_cfg
  import sercom_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout
);

  logic [CW-1:0] cfg_q;
  logic [CW-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) cfg_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CW'(CFG_RESET);
    else if (wr) cfg_q <= cfg_d;
  end

  assign dout = cfg_q;

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       wr,
  input  logic [DW-1:0] wdata,
  input  logic       wxbit,
  output logic       busy,
  output logic       txd
);

  localparam int CNTW = $clog2(2 * OVS + 1);
  localparam logic [CNTW-1:0] BIT_LAST   = CNTW'(OVS - 1);
  localparam logic [CNTW-1:0] STOP_SHORT = CNTW'(OVS - 1);
  localparam logic [CNTW-1:0] STOP_MID   = CNTW'(OVS + OVS / 2 - 1);
  localparam logic [CNTW-1:0] STOP_LONG  = CNTW'(2 * OVS - 1);

  ln_state_e        st_q, st_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [2:0]       idx_q, idx_d;
  logic [DW-1:0]    shr_q, shr_d;
  logic             opt_q, opt_d;
  logic [CNTW-1:0]  stop_last;
  logic             has_opt;

  assign has_opt = cfg.par_en | cfg.xb_en;

  always_comb begin
    if (!cfg.long_stop)          stop_last = STOP_SHORT;
    else if (cfg.len_code == 2'd0) stop_last = STOP_MID;
    else                          stop_last = STOP_LONG;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    shr_d = shr_q;
    opt_d = opt_q;
    case (st_q)
      LN_IDLE: begin
        if (wr) begin
          st_d  = LN_START;
          cnt_d = '0;
          idx_d = '0;
          shr_d = wdata;
          opt_d = cfg.par_en ? par_value(cfg, wdata) : wxbit;
        end
      end
      LN_START: begin
        if (tick) begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            st_d  = LN_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LN_DATA: begin
        if (tick) begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            shr_d = shr_q >> 1;
            if (idx_q == last_idx(cfg.len_code)) begin
              st_d = has_opt ? LN_OPT : LN_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LN_OPT: begin
        if (tick) begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            st_d  = LN_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LN_STOP: begin
        if (tick) begin
          if (cnt_q == stop_last) begin
            cnt_d = '0;
            st_d  = LN_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      shr_q <= '0;
      opt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      shr_q <= shr_d;
      opt_q <= opt_d;
    end
  end

  always_comb begin
    case (st_q)
      LN_START: txd = 1'b0;
      LN_DATA:  txd = shr_q[0];
      LN_OPT:   txd = opt_q;
      default:  txd = 1'b1;
    endcase
  end

  assign busy = (st_q != LN_IDLE);

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  frame_cfg_t    cfg,
  input  logic          rxd,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          xbit,
  output logic          valid,
  output logic          perr,
  output logic          ferr,
  output logic          ovr
);

  localparam int CNTW = $clog2(2 * OVS + 1);
  localparam logic [CNTW-1:0] BIT_LAST = CNTW'(OVS - 1);
  localparam logic [CNTW-1:0] HALF_CHK = CNTW'(OVS / 2 - 2);

  logic [SYNC-1:0] sync_q;
  logic            rx_s;

  ln_state_e       st_q, st_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [2:0]      idx_q, idx_d;
  logic [DW-1:0]   shr_q, shr_d;
  logic            opt_q, opt_d;
  logic            done;

  logic [DW-1:0]   data_q, data_d;
  logic            xbit_q, xbit_d;
  logic            valid_q, valid_d;
  logic            perr_q, perr_d;
  logic            ferr_q, ferr_d;
  logic            ovr_q, ovr_d;

  logic            has_opt;
  logic            filt_on;
  logic            keep;
  logic [DW-1:0]   aligned;

  // Input synchronizer chain; the line idles high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rxd};
  end
  assign rx_s = sync_q[SYNC-1];

  assign has_opt = cfg.par_en | cfg.xb_en;
  assign filt_on = cfg.mp_en & cfg.xb_en & ~cfg.par_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    shr_d = shr_q;
    opt_d = opt_q;
    done  = 1'b0;
    case (st_q)
      LN_IDLE: begin
        if (tick && !rx_s) begin
          st_d  = LN_START;
          cnt_d = '0;
        end
      end
      LN_START: begin
        if (tick) begin
          if (cnt_q == HALF_CHK) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rx_s ? LN_IDLE : LN_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LN_DATA: begin
        if (tick) begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            shr_d = {rx_s, shr_q[DW-1:1]};
            if (idx_q == last_idx(cfg.len_code)) begin
              st_d = has_opt ? LN_OPT : LN_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LN_OPT: begin
        if (tick) begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            opt_d = rx_s;
            st_d  = LN_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LN_STOP: begin
        if (tick) begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            done  = 1'b1;
            st_d  = LN_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      shr_q <= '0;
      opt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      shr_q <= shr_d;
      opt_q <= opt_d;
    end
  end

  // Bits enter from the top, so one right shift aligns a short character.
  assign aligned = shr_q >> (2'd3 - cfg.len_code);
  assign keep    = ~filt_on | opt_q;

  always_comb begin
    data_d  = data_q;
    xbit_d  = xbit_q;
    valid_d = valid_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    ovr_d   = ovr_q;
    if (done && keep) begin
      data_d  = aligned;
      xbit_d  = (cfg.xb_en & ~cfg.par_en) ? opt_q : 1'b0;
      perr_d  = cfg.par_en & (opt_q != par_value(cfg, aligned));
      ferr_d  = ~rx_s;
      valid_d = 1'b1;
      ovr_d   = ~rd & (ovr_q | valid_q);
    end else if (rd) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      xbit_q  <= 1'b0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      data_q  <= data_d;
      xbit_q  <= xbit_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
    end
  end

  assign data  = data_q;
  assign xbit  = xbit_q;
  assign valid = valid_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign ovr   = ovr_q;

endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
  import sercom_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_din,
  output logic [7:0] cfg_dout,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_xbit,
  output logic       tx_busy,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_xbit,
  output logic       rx_valid,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_ovr,
  output logic       txd,
  input  logic       rxd
);

  localparam int DW = 8;

  logic [1:0]  rst_pipe_q;
  logic        rst_n_s;
  frame_cfg_t  cfg;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  sercom_cfg #(.CW(DW)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n_s),
    .wr   (cfg_wr),
    .din  (cfg_din),
    .dout (cfg_dout)
  );

  assign cfg = frame_cfg_t'(cfg_dout);

  sercom_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk  (clk),
    .rst_n(rst_n_s),
    .tick (baud_tick),
    .cfg  (cfg),
    .wr   (tx_wr),
    .wdata(tx_data),
    .wxbit(tx_xbit),
    .busy (tx_busy),
    .txd  (txd)
  );

  sercom_rx #(.OVS(OVS), .DW(DW), .SYNC(2)) u_rx (
    .clk  (clk),
    .rst_n(rst_n_s),
    .tick (baud_tick),
    .cfg  (cfg),
    .rxd  (rxd),
    .rd   (rx_rd),
    .data (rx_data),
    .xbit (rx_xbit),
    .valid(rx_valid),
    .perr (rx_perr),
    .ferr (rx_ferr),
    .ovr  (rx_ovr)
  );

endmodule

// File: rtl/sercom_uart_chk.sv
module sercom_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_busy,
  input logic rx_rd,
  input logic rx_valid,
  input logic rx_ovr
);

  // R2: line rests at mark between frames
  p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R2: the first bit of every frame is a space
  p_start_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  // R10: overrun only follows an unread character
  p_ovr_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid));

  // R10: a read leaves no overrun behind
  p_read_clears_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> !rx_ovr);

  // R10: overrun never stands alone
  p_ovr_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> rx_valid);

endmodule

bind sercom_uart sercom_uart_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .txd     (txd),
  .tx_busy (tx_busy),
  .rx_rd   (rx_rd),
  .rx_valid(rx_valid),
  .rx_ovr  (rx_ovr)
);

// File: tb/sercom_uart_test.sv
`timescale 1ns/1ps
module sercom_uart_test;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       cfg_wr;
  logic [7:0] cfg_din;
  logic [7:0] cfg_dout;
  logic       tx_wr;
  logic [7:0] tx_data;
  logic       tx_xbit;
  logic       tx_busy;
  logic       rx_rd;
  logic [7:0] rx_data;
  logic       rx_xbit;
  logic       rx_valid;
  logic       rx_perr;
  logic       rx_ferr;
  logic       rx_ovr;
  logic       txd;
  logic       rxd;
  logic       loopback;
  logic       drv;

  int n_chk;
  int n_bad;

  assign rxd = loopback ? txd : drv;

  sercom_uart #(.OVS(16)) uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_wr(cfg_wr), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_xbit(tx_xbit), .tx_busy(tx_busy),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_xbit(rx_xbit), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
    .txd(txd), .rxd(rxd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // One tick every other clock: a bit is 32 clocks.
  initial baud_tick = 1'b0;
  always @(negedge clk) baud_tick <= ~baud_tick;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [7:0] mkcfg(input int lc, input bit pe, input int kind,
                                       input bit xb, input bit ls, input bit mp);
    return {mp, ls, xb, 2'(kind), pe, 2'(lc)};
  endfunction

  function automatic logic exp_par(input int kind, input int nb, input logic [7:0] d);
    int ones;
    ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    case (kind)
      0: return (ones % 2 == 0);
      1: return (ones % 2 == 1);
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_din = v;
    cfg_wr  = 1'b1;
    @(negedge clk);
    cfg_wr  = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  // Sends one character and checks its waveform and length on txd.
  task automatic tx_frame(input logic [7:0] d, input logic xb, input int nb,
                          input bit has_opt, input logic optv, input int stop_t);
    int slots;
    int n;
    int dur;
    logic expv;
    string rq;
    slots = 1 + nb + (has_opt ? 1 : 0);
    n = slots * 16 + stop_t;
    dur = -1;
    @(negedge clk);
    tx_data = d;
    tx_xbit = xb;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
    for (int c = 1; c <= 2 * n + 8; c++) begin
      @(negedge clk);
      if ((c % 32 == 16) && (c / 32 < slots)) begin
        if (c / 32 == 0) begin
          expv = 1'b0; rq = "R2 start bit";
        end else if (c / 32 <= nb) begin
          expv = d[c / 32 - 1]; rq = "R1 data bit";
        end else begin
          expv = optv; rq = "R3/R4 ninth slot";
        end
        chk(txd == expv, rq, int'(txd), int'(expv));
      end
      if (c == slots * 32 + 16) chk(txd == 1'b1, "R2 stop bit", int'(txd), 1);
      if (!tx_busy) begin
        dur = c;
        break;
      end
    end
    chk((dur == 2 * n - 1) || (dur == 2 * n), "R5 frame length", dur, 2 * n);
  endtask

  task automatic raw_frame(input logic [11:0] bits, input int nb, input int last_len);
    loopback = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      drv = bits[i];
      repeat ((i == nb - 1) ? last_len - 1 : 31) @(negedge clk);
    end
    @(negedge clk);
    drv = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] msk;
    logic       optv;
    logic       xbv;
    int         stop_t;
    bit         pe;
    bit         xb;
    int         kind;

    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    cfg_din = 8'h00;
    tx_wr = 1'b0;
    tx_data = 8'h00;
    tx_xbit = 1'b0;
    rx_rd = 1'b0;
    loopback = 1'b1;
    drv = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    chk(txd == 1'b1, "R2 reset idle line", int'(txd), 1);
    chk(tx_busy == 1'b0, "R2 reset busy", int'(tx_busy), 0);
    chk(rx_valid == 1'b0, "R10 reset valid", int'(rx_valid), 0);
    chk({rx_perr, rx_ferr, rx_ovr} == 3'b000, "R8/R9/R10 reset flags",
        int'({rx_perr, rx_ferr, rx_ovr}), 0);
    chk(cfg_dout == 8'h03, "R13 reset config", int'(cfg_dout), 8'h03);

    // Loopback sweep: every length, parity kind, extra bit and stop length
    for (int lc = 0; lc < 4; lc++) begin
      for (int pm = 0; pm < 7; pm++) begin
        for (int ls = 0; ls < 2; ls++) begin
          pe   = (pm >= 1 && pm <= 4) || (pm == 6);
          kind = (pm >= 1 && pm <= 4) ? pm - 1 : 0;
          xb   = (pm >= 5);
          set_cfg(mkcfg(lc, pe, kind, xb, ls[0], 1'b0));
          chk(cfg_dout == mkcfg(lc, pe, kind, xb, ls[0], 1'b0), "R13 config readback",
              int'(cfg_dout), int'(mkcfg(lc, pe, kind, xb, ls[0], 1'b0)));
          for (int di = 0; di < 3; di++) begin
            d = (di == 0) ? 8'h00 : (di == 1) ? 8'hFF : 8'((lc * 29 + pm * 53 + ls * 17 + 101) & 255);
            msk = 8'hFF >> (3 - lc);
            if (pe) optv = exp_par(kind, lc + 5, d);
            else    optv = 1'(di % 2);
            // With both enabled, offer the opposite of parity to prove precedence.
            xbv = (pm == 6) ? ~optv : 1'(di % 2);
            stop_t = (ls == 0) ? 16 : (lc == 0 ? 24 : 32);
            tx_frame(d, xbv, lc + 5, pe || xb, optv, stop_t);
            repeat (2) @(negedge clk);
            chk(rx_valid == 1'b1, "R13 loopback valid", int'(rx_valid), 1);
            chk(rx_data == (d & msk), "R6 received data", int'(rx_data), int'(d & msk));
            chk(rx_xbit == ((xb && !pe) ? xbv : 1'b0), "R4/R6 received extra bit",
                int'(rx_xbit), int'((xb && !pe) ? xbv : 1'b0));
            chk(rx_perr == 1'b0, "R8 no parity error", int'(rx_perr), 0);
            chk(rx_ferr == 1'b0, "R9 no framing error", int'(rx_ferr), 0);
            read_rx();
            chk(rx_valid == 1'b0, "R10 read clears valid", int'(rx_valid), 0);
          end
        end
      end
    end

    // R12: second write during a frame is dropped
    set_cfg(mkcfg(3, 1'b0, 0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    tx_data = 8'h96; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (100) @(negedge clk);
    tx_data = 8'h3A; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    while (tx_busy) @(negedge clk);
    chk(rx_data == 8'h96, "R12 frame unchanged", int'(rx_data), 8'h96);
    repeat (60) @(negedge clk);
    chk(tx_busy == 1'b0, "R12 no second frame busy", int'(tx_busy), 0);
    chk(txd == 1'b1, "R12 no second frame line", int'(txd), 1);
    read_rx();

    // R7: short glitch then a real frame
    loopback = 1'b0;
    @(negedge clk);
    drv = 1'b0;
    repeat (6) @(negedge clk);
    drv = 1'b1;
    repeat (400) @(negedge clk);
    chk(rx_valid == 1'b0, "R7 glitch ignored", int'(rx_valid), 0);
    raw_frame({2'b11, 8'h5E, 1'b0}, 11, 32);
    chk(rx_valid == 1'b1 && rx_data == 8'h5E, "R7 frame after glitch", int'(rx_data), 8'h5E);
    read_rx();

    // R8: even parity, data 0xA5 has four ones so parity 0; send 1
    set_cfg(mkcfg(3, 1'b1, 1, 1'b0, 1'b0, 1'b0));
    raw_frame({2'b11, 8'hA5, 1'b0}, 11, 32);
    chk(rx_perr == 1'b1, "R8 parity error flagged", int'(rx_perr), 1);
    chk(rx_data == 8'hA5, "R8 data kept", int'(rx_data), 8'hA5);
    read_rx();
    raw_frame({2'b10, 8'hA5, 1'b0}, 11, 32);
    chk(rx_perr == 1'b0, "R8 good parity", int'(rx_perr), 0);
    read_rx();

    // R9: stop bit low for half a bit
    set_cfg(mkcfg(3, 1'b0, 0, 1'b0, 1'b0, 1'b0));
    raw_frame({2'b00, 8'h81, 1'b0}, 10, 16);
    chk(rx_ferr == 1'b1, "R9 framing error flagged", int'(rx_ferr), 1);
    chk(rx_data == 8'h81, "R9 data kept", int'(rx_data), 8'h81);
    chk(rx_ovr == 1'b0, "R9 no spurious frame", int'(rx_ovr), 0);
    read_rx();

    // R10: two characters without a read
    raw_frame({2'b01, 8'h3C, 1'b0}, 10, 32);
    chk(rx_ovr == 1'b0, "R10 first frame no overrun", int'(rx_ovr), 0);
    raw_frame({2'b01, 8'hC3, 1'b0}, 10, 32);
    chk(rx_ovr == 1'b1, "R10 overrun flagged", int'(rx_ovr), 1);
    chk(rx_data == 8'hC3, "R10 newer character kept", int'(rx_data), 8'hC3);
    read_rx();
    chk({rx_valid, rx_ovr} == 2'b00, "R10 read clears flags", int'({rx_valid, rx_ovr}), 0);

    // R11: address filtering over loopback
    loopback = 1'b1;
    set_cfg(mkcfg(3, 1'b0, 0, 1'b1, 1'b0, 1'b1));
    tx_frame(8'h47, 1'b0, 8, 1'b1, 1'b0, 16);
    repeat (2) @(negedge clk);
    chk(rx_valid == 1'b0, "R11 data frame dropped", int'(rx_valid), 0);
    chk(rx_data == 8'h3C ^ 8'hFF, "R11 data output untouched", int'(rx_data), 8'hC3);
    tx_frame(8'h12, 1'b1, 8, 1'b1, 1'b1, 16);
    repeat (2) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'h12, "R11 address frame kept", int'(rx_data), 8'h12);
    chk(rx_xbit == 1'b1, "R11 address extra bit", int'(rx_xbit), 1);
    read_rx();
    // Filter bit without extra bit enabled has no effect
    set_cfg(mkcfg(3, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    tx_frame(8'h6D, 1'b0, 8, 1'b0, 1'b0, 16);
    repeat (2) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'h6D, "R11 filter inactive", int'(rx_data), 8'h6D);
    read_rx();

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule